// File: doc/BRIEF.md
# Low-Voltage Monitor Status Controller

This block collects the outputs of five supply-voltage comparators and turns them into sticky event flags that software reads through a small register interface. The five supplies are the I/O segment that carries the reset pin, the high-voltage I/O supply, the 5V regulator supply, the 3.3V supply and the 1.2V supply. Each comparator output is synchronized to the block clock. While it is high, the matching flag is set. The flag stays set until software clears it or until a reset clears it.

Each supply has an interrupt enable and a reset enable, both held in a control register. The block drives one combined interrupt request. It also drives a one-cycle system reset request whenever a flag is set and that flag's reset enable is on. The triggered reset returns the flags and the enables to their reset values, and this removes the interrupt request.

Software clears a flag by writing 1 to a separate clear bit in the status word. The clear bits are write-only and always read back as 0. Writes to the flag bits themselves have no effect.

Top module: `lvm_status_ctrl`

## Requirements
- R1: After `rst`, all flags and all enables read 0, and `irq_o` and `sys_rst_req_o` are low.
- R2: Supply index i uses comparator input bit i. The index order is reset-pin supply 0, high-voltage I/O 1, 5V 2, 3.3V 3, 1.2V 4. A high input sets status bit 24+i at the third rising edge after the input is applied, because the input first passes two synchronizer flops.
- R3: A set flag stays set after its comparator input returns low.
- R4: A write to the status register (`bus_sel_i`=0) with byte strobe 2 (`bus_wstrb_i[2]`) high clears flag i when `bus_wdata_i[16+i]` is 1. A write whose data bit is 0, or whose byte strobe 2 is low, leaves the flag unchanged.
- R5: Status bits 16 to 23 and bits 29 to 31 always read 0. Control bits 5 to 7 and bits 13 to 31 always read 0.
- R6: Writing the status register with byte strobe 3 high and any data in bits 24 to 31 leaves the flags unchanged.
- R7: When the synchronized comparator level is high in the same cycle as a clear of that flag, the flag stays set.
- R8: `irq_o` is high exactly when at least one flag is set whose interrupt enable is 1. The interrupt enables are control bits 0 to 4, in supply order.
- R9: The reset enables are control bits 8 to 12, in supply order. A set flag whose reset enable is 1 raises `sys_rst_req_o` one cycle after the flag is visible. The request lasts one cycle. At its end, all flags and all enables are 0 and `irq_o` is low.
- R10: A control write (`bus_sel_i`=1) updates the interrupt enables only when `bus_wstrb_i[0]` is high, and updates the reset enables only when `bus_wstrb_i[1]` is high. The written values read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_below_i | input | 5 | Comparator outputs (high means below threshold), one per supply |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_sel_i | input | 1 | Register select: 0 status, 1 control |
| bus_wdata_i | input | 32 | Write data |
| bus_wstrb_i | input | 4 | Byte write enables |
| bus_rdata_o | output | 32 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Combined interrupt request |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions watch properties that must hold on every cycle:
- A high synchronized level always shows up as a set flag.
- A flag never drops unless a clear or a triggered reset explains it.
- The reset request lasts one cycle and always has a flag with its reset enable behind it.
- After that request, the flags and the enables are 0.
- The clear field always reads 0.

Only the bench scenarios can show the exact three-edge latency from the comparator input to the flag. They also show the strobe-gated and zero-data writes that must not clear a flag, and the race between a set and a clear. Finally, they show the full sequence from flag to interrupt, to reset pulse, and back to an idle state.

// File: rtl/lvm_pkg.sv
package lvm_pkg;

    localparam int NSUP    = 5;
    localparam int DATA_W  = 32;
    localparam int STRB_W  = DATA_W / 8;
    localparam int SYNC_N  = 2;

    // Status word layout
    localparam int CLR_LSB = 16;
    localparam int FLG_LSB = 24;
    // Control word layout
    localparam int IE_LSB  = 0;
    localparam int RE_LSB  = 8;

    localparam int CLR_BYTE = CLR_LSB / 8;
    localparam int IE_BYTE  = IE_LSB / 8;
    localparam int RE_BYTE  = RE_LSB / 8;

    typedef logic [NSUP-1:0]   sup_vec_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic {
        REG_STATUS = 1'b0,
        REG_CTRL   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        sup_vec_t irq_en;
        sup_vec_t rst_en;
    } ctrl_t;

    function automatic sup_vec_t field_get(input word_t w, input int lsb);
        word_t sh;
        sh = w >> lsb;
        return sh[NSUP-1:0];
    endfunction

    function automatic word_t field_put(input sup_vec_t v, input int lsb);
        word_t w;
        w = word_t'(v);
        return w << lsb;
    endfunction

endpackage

// File: rtl/lvm_sync.sv
module lvm_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/lvm_flag_bank.sv
module lvm_flag_bank
    import lvm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sup_vec_t set_i,
    input  sup_vec_t clr_i,
    input  logic     sysclr_i,
    output sup_vec_t flag_o
);

    for (genvar g = 0; g < NSUP; g++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk) begin
            if (rst || sysclr_i) f_q <= 1'b0;
            else if (set_i[g])   f_q <= 1'b1;   // set beats a clear
            else if (clr_i[g])   f_q <= 1'b0;
        end
        assign flag_o[g] = f_q;
    end

endmodule

// File: rtl/lvm_ctrl_regs.sv
module lvm_ctrl_regs
    import lvm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sysclr_i,
    input  logic     ie_we_i,
    input  logic     re_we_i,
    input  sup_vec_t ie_d_i,
    input  sup_vec_t re_d_i,
    output ctrl_t    ctrl_o
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst || sysclr_i) begin
            ctrl_q <= '0;
        end else begin
            if (ie_we_i) ctrl_q.irq_en <= ie_d_i;
            if (re_we_i) ctrl_q.rst_en <= re_d_i;
        end
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/lvm_reset_gen.sv
module lvm_reset_gen
    import lvm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sup_vec_t flag_i,
    input  sup_vec_t rst_en_i,
    output logic     req_o
);

    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= !req_q && ((flag_i & rst_en_i) != '0);
    end

    assign req_o = req_q;

endmodule

// File: rtl/lvm_status_ctrl.sv
module lvm_status_ctrl
    import lvm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  mon_below_i,
    input  logic        bus_wr_i,
    input  logic        bus_sel_i,
    input  logic [31:0] bus_wdata_i,
    input  logic [3:0]  bus_wstrb_i,
    output logic [31:0] bus_rdata_o,
    output logic        irq_o,
    output logic        sys_rst_req_o
);

    reg_sel_e sel;
    sup_vec_t sync_q;
    sup_vec_t clr_mask;
    sup_vec_t flag_q;
    ctrl_t    ctrl;
    logic     sysclr;
    logic     ctrl_we;
    logic     unused_wr_bits;

    assign sel     = reg_sel_e'(bus_sel_i);
    assign ctrl_we = bus_wr_i && (sel == REG_CTRL);

    always_comb begin
        clr_mask = '0;
        if (bus_wr_i && sel == REG_STATUS && bus_wstrb_i[CLR_BYTE])
            clr_mask = field_get(bus_wdata_i, CLR_LSB);
    end

    lvm_sync #(.WIDTH(NSUP), .STAGES(SYNC_N)) i_sync (
        .clk (clk),
        .rst (rst),
        .d_i (mon_below_i),
        .q_o (sync_q)
    );

    lvm_flag_bank i_flags (
        .clk      (clk),
        .rst      (rst),
        .set_i    (sync_q),
        .clr_i    (clr_mask),
        .sysclr_i (sysclr),
        .flag_o   (flag_q)
    );

    lvm_ctrl_regs i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sysclr_i (sysclr),
        .ie_we_i  (ctrl_we && bus_wstrb_i[IE_BYTE]),
        .re_we_i  (ctrl_we && bus_wstrb_i[RE_BYTE]),
        .ie_d_i   (field_get(bus_wdata_i, IE_LSB)),
        .re_d_i   (field_get(bus_wdata_i, RE_LSB)),
        .ctrl_o   (ctrl)
    );

    lvm_reset_gen i_rstgen (
        .clk      (clk),
        .rst      (rst),
        .flag_i   (flag_q),
        .rst_en_i (ctrl.rst_en),
        .req_o    (sysclr)
    );

    always_comb begin
        case (sel)
            REG_STATUS: bus_rdata_o = field_put(flag_q, FLG_LSB);
            default:    bus_rdata_o = field_put(ctrl.irq_en, IE_LSB)
                                    | field_put(ctrl.rst_en, RE_LSB);
        endcase
    end

    assign irq_o          = (flag_q & ctrl.irq_en) != '0;
    assign sys_rst_req_o  = sysclr;
    assign unused_wr_bits = ^{bus_wdata_i, bus_wstrb_i};

endmodule

// File: rtl/lvm_status_sva.sv
module lvm_status_sva
    import lvm_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input sup_vec_t sync_q,
    input sup_vec_t clr_mask,
    input sup_vec_t flags,
    input sup_vec_t ie,
    input sup_vec_t re,
    input logic     irq,
    input logic     sys_rst,
    input word_t    rdata
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (flags == '0 && ie == '0 && re == '0 && !sys_rst));

    p_sync_sets_flag_r2: assert property (@(posedge clk) disable iff (rst)
        (sync_q != '0 && !sys_rst) |=> ((flags & $past(sync_q)) == $past(sync_q)));

    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (!sys_rst && clr_mask == '0) |=> ((flags & $past(flags)) == $past(flags)));

    p_clear_field_zero_r5: assert property (@(posedge clk) disable iff (rst)
        rdata[23:16] == 8'h00);

    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0));

    p_rst_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        sys_rst |=> !sys_rst);

    p_rst_clears_state_r9: assert property (@(posedge clk) disable iff (rst)
        sys_rst |=> (flags == '0 && ie == '0 && re == '0 && !irq));

    p_rst_has_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst) |-> $past((flags & re) != '0));

endmodule

bind lvm_status_ctrl lvm_status_sva i_lvm_status_sva (
    .clk      (clk),
    .rst      (rst),
    .sync_q   (sync_q),
    .clr_mask (clr_mask),
    .flags    (flag_q),
    .ie       (ctrl.irq_en),
    .re       (ctrl.rst_en),
    .irq      (irq_o),
    .sys_rst  (sys_rst_req_o),
    .rdata    (bus_rdata_o)
);

// File: tb/test_lvm_status_ctrl.sv
module test_lvm_status_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  below;
    logic        wr;
    logic        sel;
    logic [31:0] wdata;
    logic [3:0]  wstrb;
    logic [31:0] rdata;
    logic        irq;
    logic        sysrst;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    lvm_status_ctrl i_lvm_status_ctrl (
        .clk           (clk),
        .rst           (rst),
        .mon_below_i   (below),
        .bus_wr_i      (wr),
        .bus_sel_i     (sel),
        .bus_wdata_i   (wdata),
        .bus_wstrb_i   (wstrb),
        .bus_rdata_o   (rdata),
        .irq_o         (irq),
        .sys_rst_req_o (sysrst)
    );

    typedef struct packed {
        logic [4:0]  below;
        logic        wr;
        logic        sel;
        logic [31:0] wdata;
        logic [3:0]  wstrb;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{5'b00001, 1'b0, 1'b0, 32'h0000_0000, 4'b0000, 32'h0100_0000, 1'b0, 8'd2},  // R2
        '{5'b00000, 1'b0, 1'b0, 32'h0000_0000, 4'b0000, 32'h0100_0000, 1'b0, 8'd3},  // R3
        '{5'b00000, 1'b1, 1'b0, 32'h0000_0000, 4'b0100, 32'h0100_0000, 1'b0, 8'd4},  // R4 zero data
        '{5'b00000, 1'b1, 1'b0, 32'h0001_0000, 4'b1000, 32'h0100_0000, 1'b0, 8'd4},  // R4 strobe off
        '{5'b00000, 1'b1, 1'b0, 32'h001F_0000, 4'b0100, 32'h0000_0000, 1'b0, 8'd4},  // R4 clear
        '{5'b10110, 1'b0, 1'b0, 32'h0000_0000, 4'b0000, 32'h1600_0000, 1'b0, 8'd2},  // R2
        '{5'b00000, 1'b1, 1'b0, 32'hFF00_0000, 4'b1000, 32'h1600_0000, 1'b0, 8'd6},  // R6
        '{5'b00000, 1'b1, 1'b0, 32'h0004_0000, 4'b0100, 32'h1200_0000, 1'b0, 8'd4},  // R4
        '{5'b00000, 1'b1, 1'b1, 32'h0000_0002, 4'b0001, 32'h0000_0002, 1'b1, 8'd8},  // R8 R10
        '{5'b00000, 1'b1, 1'b1, 32'h0000_0004, 4'b0010, 32'h0000_0002, 1'b1, 8'd10}, // R10
        '{5'b00000, 1'b1, 1'b0, 32'h0002_0000, 4'b0100, 32'h1000_0000, 1'b0, 8'd8},  // R8
        '{5'b00000, 1'b1, 1'b1, 32'h0000_00FF, 4'b0001, 32'h0000_001F, 1'b1, 8'd5},  // R5 R10
        '{5'b00000, 1'b1, 1'b0, 32'h0010_0000, 4'b0100, 32'h0000_0000, 1'b0, 8'd8}   // R8
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic s, input logic [31:0] d, input logic [3:0] b);
        sel = s; wdata = d; wstrb = b; wr = 1'b1;
        tick();
        wr = 1'b0; wstrb = 4'b0000;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; below = '0; wr = 1'b0; sel = 1'b0; wdata = '0; wstrb = '0;
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        sel = 1'b0; #1;
        chk(rdata == 32'h0, "R1 status", rdata, 32'h0);
        sel = 1'b1; #1;
        chk(rdata == 32'h0, "R1 control", rdata, 32'h0);
        chk({irq, sysrst} == 2'b00, "R1 outputs", {30'd0, irq, sysrst}, 32'h0);

        // Table walk: level settles through the synchronizer, then the write
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            below = VECS[v].below;
            tick(); tick();
            if (VECS[v].wr) bus_write(VECS[v].sel, VECS[v].wdata, VECS[v].wstrb);
            else            tick();
            tick();
            sel = VECS[v].sel; #1;
            n_tests++;
            if (rdata !== VECS[v].exp_rd) begin
                n_fail++;
                $display("FAIL R%0d vec %0d rdata actual=%h expected=%h",
                         VECS[v].req, v, rdata, VECS[v].exp_rd);
            end
            n_tests++;
            if (irq !== VECS[v].exp_irq) begin
                n_fail++;
                $display("FAIL R%0d vec %0d irq actual=%h expected=%h",
                         VECS[v].req, v, irq, VECS[v].exp_irq);
            end
        end

        // R7: clear during a high synchronized level loses
        @(negedge clk);
        below = 5'b01000;
        tick(); tick(); tick();
        bus_write(1'b0, 32'h0008_0000, 4'b0100);
        sel = 1'b0; #1;
        chk(rdata == 32'h0800_0000, "R7 set wins", rdata, 32'h0800_0000);
        below = 5'b00000;
        tick(); tick();
        bus_write(1'b0, 32'h0008_0000, 4'b0100);
        sel = 1'b0; #1;
        chk(rdata == 32'h0, "R4 clear after drop", rdata, 32'h0);

        // R9: reset path on the reset-pin supply
        bus_write(1'b1, 32'h0000_0101, 4'b0011);
        sel = 1'b1; #1;
        chk(rdata == 32'h0000_0101, "R10 control readback", rdata, 32'h0000_0101);
        @(negedge clk);
        below = 5'b00001;
        tick();               // E1
        below = 5'b00000;
        tick();               // E2
        tick();               // E3: flag visible
        chk({irq, sysrst} == 2'b10, "R9 flag before request", {30'd0, irq, sysrst}, 32'h2);
        tick();               // E4: request
        sel = 1'b0; #1;
        chk(sysrst == 1'b1, "R9 request raised", {31'd0, sysrst}, 32'h1);
        chk(rdata == 32'h0100_0000, "R9 flag during request", rdata, 32'h0100_0000);
        tick();               // E5: cleared
        chk({irq, sysrst} == 2'b00, "R9 after request", {30'd0, irq, sysrst}, 32'h0);
        chk(rdata == 32'h0, "R9 flags cleared", rdata, 32'h0);
        sel = 1'b1; #1;
        chk(rdata == 32'h0, "R9 enables cleared", rdata, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule